// File: doc/BRIEF.md
# Boot configuration sequencer

This block is a bus master that brings a slave controller into service after reset, with no software involved. It holds a constant table of register writes, sorted into groups. It plays each group to the slave over a simple 32-bit read/write port. Around each group it runs the slave's handshakes:

- Before the group's writes, it asks for a root update and waits until the slave reports that it is ready.
- After the writes, it commits each table entry of the group. A commit is an entry-number write, then an update trigger, then a wait for the entry's acknowledge, then a clear, then a wait for all acknowledges to drop.

A single start pulse launches the whole sequence. The `done` output rises when every group has been committed. The `error` output rises when any wait runs past its time limit. The limit is a number of microseconds, converted to clock cycles from a clock-frequency parameter. On an error the sequencer records which group and which kind of wait failed, stops issuing bus traffic and returns to idle. A later start pulse runs the whole sequence again from the first group.

Top module: `cfg_boot_seq`

## Requirements
- R1: Groups are played in this fixed order:
  - group 0: 3 words at offsets 0x30, 0x34, 0x38, base entry 6
  - group 1: 8 words at offsets 0x10 to 0x2C, base entry 14
  - group 2: 1 word at offset 0x40, base entry 3
  - groups 3, 4 and 5: single words 0x800, 0xC00 and 0x400 at offset 0x50, each with base entry 2

  All offsets are added to `BASE_ADDR`, and words go out in ascending table order inside a group.
- R2: Each group opens with a read-modify-write of the command register (offset 0x00) that sets bit 1. The sequencer then re-reads that register until its bit 0 reads 0. No table word is written while the slave still reports bit 0 set.
- R3: After a group of n words, entries are committed in descending order: base, base-1, and so on down to base-n+1.
- R4: A commit makes two read-modify-write steps on the update register (offset 0x60). The first ORs in the entry number. The second, a separate write, ORs in bit 8.
- R5: After the trigger, the sequencer polls the update register until bit (16+entry) is set. It then writes the whole word to 0 and polls until bits 31:16 all read 0. Only after that does it start the next commit or group.
- R6: A wait that has not succeeded after `CLK_HZ/1e6*TIMEOUT_US` cycles ends the sequence, and the sequencer returns to idle with no further bus requests. The wait may be for ready, acknowledge or acknowledge-clear.
  - `error` is set and `done` stays low.
  - `err_group` holds the group number.
  - `err_poll` holds the wait kind: 0 = ready, 1 = acknowledge, 2 = acknowledge-clear.
- R7: `done` rises after the last commit of the last group and holds until the next accepted start. An accepted start clears both `done` and `error`.
- R8: A start pulse that arrives while a sequence is running is ignored, and the bus traffic stays exactly the R1 to R5 sequence.
- R9: After reset, `done`, `error` and `bus_valid` are low, and `err_poll` reads 3 (no failure).
- R10: A bus request keeps `bus_addr`, `bus_write` and `bus_wdata` stable, with `bus_valid` high, until the cycle in which `bus_ready` is high. At most one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| done | output | 1 | Whole sequence completed |
| error | output | 1 | A wait timed out; sequence stopped |
| err_group | output | 3 | Group in which the timeout happened |
| err_poll | output | 2 | Kind of wait that timed out (3 = none) |
| bus_valid | output | 1 | Request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address of the request |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Slave accepts the request this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |

## Verification
The bus request appears one cycle after the sequencer decides to issue it. It is accepted in the cycle where `bus_valid` and `bus_ready` are both high. The sequencer acts on read data one cycle after that handshake. The scoreboard therefore compares each write on the falling edge inside its handshake cycle. That is the only point where the request and the acceptance are both visible. `done`, `error` and the failure fields are checked on falling edges only after the bench has seen them change. The time limit is checked against the cycle count from the start pulse to `error`, and bus silence is then watched over a following window.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

   localparam int NUM_WORDS  = 15;
   localparam int NUM_GROUPS = 6;
   localparam int GRP_W      = 3;
   localparam int IDX_W      = 5;

   // register offsets and bit positions the slave decodes
   localparam logic [7:0] CMD_OFF   = 8'h00;
   localparam logic [7:0] UPD_OFF   = 8'h60;
   localparam int         BUSY_BIT  = 0;
   localparam int         ROOT_BIT  = 1;
   localparam int         TRIG_BIT  = 8;
   localparam int         ACK_LSB   = 16;

   typedef enum logic [1:0] {
      PK_READY  = 2'd0,
      PK_ACK    = 2'd1,
      PK_ACKCLR = 2'd2,
      PK_NONE   = 2'd3
   } poll_kind_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_ROOT,
      ST_WR_ROOT,
      ST_POLL_RDY,
      ST_WR_ITEM,
      ST_CE_RD_NUM,
      ST_CE_WR_NUM,
      ST_CE_RD_TRIG,
      ST_CE_WR_TRIG,
      ST_POLL_ACK,
      ST_CE_CLR,
      ST_POLL_CLR
   } seq_state_e;

   typedef struct packed {
      logic [7:0]  off;
      logic [31:0] val;
   } wr_item_t;

   typedef struct packed {
      logic [IDX_W-1:0] entry;
      logic [IDX_W-1:0] first;
      logic [IDX_W-1:0] count;
   } grp_desc_t;

   function automatic wr_item_t item_at(input int i);
      wr_item_t r;
      case (i)
         0:  r = '{off: 8'h30, val: 32'h0777_06DB};
         1:  r = '{off: 8'h34, val: 32'h0555_0249};
         2:  r = '{off: 8'h38, val: 32'h0000_0111};
         3:  r = '{off: 8'h10, val: 32'hFEFE_BFF7};
         4:  r = '{off: 8'h14, val: 32'hFDFF_7FEF};
         5:  r = '{off: 8'h18, val: 32'hFBFF_DEFB};
         6:  r = '{off: 8'h1C, val: 32'hB69B_5555};
         7:  r = '{off: 8'h20, val: 32'h2492_9249};
         8:  r = '{off: 8'h24, val: 32'h4924_1112};
         9:  r = '{off: 8'h28, val: 32'h1111_2111};
         10: r = '{off: 8'h2C, val: 32'h0000_8102};
         11: r = '{off: 8'h40, val: 32'h000F_C987};
         12: r = '{off: 8'h50, val: 32'h0000_0800};
         13: r = '{off: 8'h50, val: 32'h0000_0C00};
         14: r = '{off: 8'h50, val: 32'h0000_0400};
         default: r = '0;
      endcase
      return r;
   endfunction

   // group order is behaviour: limits, scaling, link, then three enable steps
   function automatic grp_desc_t group_at(input int g);
      grp_desc_t r;
      case (g)
         0: r = '{entry: 5'd6,  first: 5'd0,  count: 5'd3};
         1: r = '{entry: 5'd14, first: 5'd3,  count: 5'd8};
         2: r = '{entry: 5'd3,  first: 5'd11, count: 5'd1};
         3: r = '{entry: 5'd2,  first: 5'd12, count: 5'd1};
         4: r = '{entry: 5'd2,  first: 5'd13, count: 5'd1};
         5: r = '{entry: 5'd2,  first: 5'd14, count: 5'd1};
         default: r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cfgseq_rom.sv
module cfgseq_rom
   import cfgseq_pkg::*;
(
   input  logic [GRP_W-1:0] grp_sel,
   input  logic [IDX_W-1:0] word_sel,
   output grp_desc_t        grp,
   output wr_item_t         item
);

   grp_desc_t grp_tab  [NUM_GROUPS];
   wr_item_t  item_tab [NUM_WORDS];

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_tab[g] = group_at(g);
   end

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      assign item_tab[w] = item_at(w);
   end

   logic [IDX_W-1:0] flat_idx;

   always_comb begin
      if (int'(grp_sel) < NUM_GROUPS) grp = grp_tab[grp_sel];
      else                            grp = '0;
      flat_idx = grp.first + word_sel;
      if (int'(flat_idx) < NUM_WORDS) item = item_tab[flat_idx];
      else                            item = '0;
   end

endmodule

// File: rtl/cfgseq_timer.sv
module cfgseq_timer #(
   parameter int LIMIT = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   localparam int CNT_W = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("cfgseq_timer: LIMIT must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cnt <= '0;
      else if (!run)                        cnt <= '0;
      else if (cnt != CNT_W'(LIMIT))        cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == CNT_W'(LIMIT));

endmodule

// File: rtl/cfgseq_bus.sv
module cfgseq_bus #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              go_write,
   input  logic [ADDR_W-1:0] go_addr,
   input  logic [DATA_W-1:0] go_wdata,
   output logic              op_done,
   output logic [DATA_W-1:0] op_rdata,
   output logic              bus_valid,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ready,
   input  logic [DATA_W-1:0] bus_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_valid <= 1'b0;
         bus_write <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         op_done   <= 1'b0;
         op_rdata  <= '0;
      end else begin
         op_done <= bus_valid && bus_ready;
         if (bus_valid && bus_ready) begin
            bus_valid <= 1'b0;
            if (!bus_write) op_rdata <= bus_rdata;
         end else if (go && !bus_valid) begin
            bus_valid <= 1'b1;
            bus_write <= go_write;
            bus_addr  <= go_addr;
            bus_wdata <= go_wdata;
         end
      end
   end

endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
   import cfgseq_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          CLK_HZ     = 100_000_000,
   parameter int          TIMEOUT_US = 500,
   parameter logic [31:0] BASE_ADDR  = 32'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic              error,
   output logic [GRP_W-1:0]  err_group,
   output logic [1:0]        err_poll,
   output logic              bus_valid,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [31:0]       bus_wdata,
   input  logic              bus_ready,
   input  logic [31:0]       bus_rdata
);

   localparam int DATA_W      = 32;
   localparam int CYC_PER_US  = CLK_HZ / 1_000_000;
   localparam int POLL_LIMIT  = CYC_PER_US * TIMEOUT_US;
   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(BASE_ADDR + 32'(CMD_OFF));
   localparam logic [ADDR_W-1:0] A_UPD = ADDR_W'(BASE_ADDR + 32'(UPD_OFF));

   if (CLK_HZ < 1_000_000) begin : g_bad_clk
      $error("cfg_boot_seq: CLK_HZ must be at least 1 MHz");
   end
   if (TIMEOUT_US < 1) begin : g_bad_to
      $error("cfg_boot_seq: TIMEOUT_US must be at least 1");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
      $error("cfg_boot_seq: ADDR_W must be 8..32");
   end
   if (ADDR_W < 32) begin : g_chk_span
      if (BASE_ADDR + 32'h100 > (32'h1 << ADDR_W)) begin : g_bad_base
         $error("cfg_boot_seq: register window exceeds address space");
      end
   end

   seq_state_e        st;
   logic              issued;
   logic [GRP_W-1:0]  grp;
   logic [IDX_W-1:0]  widx;
   logic [IDX_W-1:0]  eoff;
   grp_desc_t         gd;
   wr_item_t          wi;
   logic              running;

   logic              go;
   logic              op_write;
   logic [ADDR_W-1:0] op_addr;
   logic [31:0]       op_wdata;
   logic              op_done;
   logic [31:0]       rdq;
   logic              in_poll;
   logic              expired;
   logic [IDX_W-1:0]  ent;
   logic [15:0]       ack_field;
   logic              ack_hit;
   logic              last_word;
   logic              last_entry;
   logic              last_group;

   cfgseq_rom u_rom (
      .grp_sel  (grp),
      .word_sel (widx),
      .grp      (gd),
      .item     (wi)
   );

   cfgseq_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .go_write  (op_write),
      .go_addr   (op_addr),
      .go_wdata  (op_wdata),
      .op_done   (op_done),
      .op_rdata  (rdq),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_ready (bus_ready),
      .bus_rdata (bus_rdata)
   );

   cfgseq_timer #(.LIMIT(POLL_LIMIT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (in_poll),
      .expired (expired)
   );

   assign running    = (st != ST_IDLE);
   assign go         = running && !issued;
   assign in_poll    = (st == ST_POLL_RDY) || (st == ST_POLL_ACK) || (st == ST_POLL_CLR);
   assign ent        = gd.entry - eoff;
   assign ack_field  = rdq[ACK_LSB +: 16];
   assign ack_hit    = ack_field[ent[3:0]];
   assign last_word  = (widx == gd.count - 1'b1);
   assign last_entry = (eoff == gd.count - 1'b1);
   assign last_group = (int'(grp) == NUM_GROUPS - 1);

   // request decode per state
   always_comb begin
      op_write = 1'b0;
      op_addr  = A_UPD;
      op_wdata = '0;
      unique case (st)
         ST_RD_ROOT, ST_POLL_RDY: op_addr = A_CMD;
         ST_WR_ROOT: begin
            op_write = 1'b1;
            op_addr  = A_CMD;
            op_wdata = rdq | (32'h1 << ROOT_BIT);
         end
         ST_WR_ITEM: begin
            op_write = 1'b1;
            op_addr  = ADDR_W'(BASE_ADDR + 32'(wi.off));
            op_wdata = wi.val;
         end
         ST_CE_WR_NUM: begin
            op_write = 1'b1;
            op_wdata = rdq | 32'(ent);
         end
         ST_CE_WR_TRIG: begin
            op_write = 1'b1;
            op_wdata = rdq | (32'h1 << TRIG_BIT);
         end
         ST_CE_CLR: op_write = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         issued    <= 1'b0;
         grp       <= '0;
         widx      <= '0;
         eoff      <= '0;
         done      <= 1'b0;
         error     <= 1'b0;
         err_group <= '0;
         err_poll  <= PK_NONE;
      end else begin
         if (go) issued <= 1'b1;
         if (st == ST_IDLE) begin
            if (start) begin
               done      <= 1'b0;
               error     <= 1'b0;
               err_group <= '0;
               err_poll  <= PK_NONE;
               grp       <= '0;
               st        <= ST_RD_ROOT;
            end
         end else if (op_done) begin
            issued <= 1'b0;
            unique case (st)
               ST_RD_ROOT: st <= ST_WR_ROOT;
               ST_WR_ROOT: st <= ST_POLL_RDY;
               ST_POLL_RDY: begin
                  if (!rdq[BUSY_BIT]) begin
                     widx <= '0;
                     st   <= ST_WR_ITEM;
                  end else if (expired) begin
                     st        <= ST_IDLE;
                     error     <= 1'b1;
                     err_group <= grp;
                     err_poll  <= PK_READY;
                  end
               end
               ST_WR_ITEM: begin
                  if (last_word) begin
                     eoff <= '0;
                     st   <= ST_CE_RD_NUM;
                  end else begin
                     widx <= widx + 1'b1;
                  end
               end
               ST_CE_RD_NUM:  st <= ST_CE_WR_NUM;
               ST_CE_WR_NUM:  st <= ST_CE_RD_TRIG;
               ST_CE_RD_TRIG: st <= ST_CE_WR_TRIG;
               ST_CE_WR_TRIG: st <= ST_POLL_ACK;
               ST_POLL_ACK: begin
                  if (ack_hit) begin
                     st <= ST_CE_CLR;
                  end else if (expired) begin
                     st        <= ST_IDLE;
                     error     <= 1'b1;
                     err_group <= grp;
                     err_poll  <= PK_ACK;
                  end
               end
               ST_CE_CLR: st <= ST_POLL_CLR;
               ST_POLL_CLR: begin
                  if (ack_field == 16'h0) begin
                     if (!last_entry) begin
                        eoff <= eoff + 1'b1;
                        st   <= ST_CE_RD_NUM;
                     end else if (last_group) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                     end else begin
                        grp <= grp + 1'b1;
                        st  <= ST_RD_ROOT;
                     end
                  end else if (expired) begin
                     st        <= ST_IDLE;
                     error     <= 1'b1;
                     err_group <= grp;
                     err_poll  <= PK_ACKCLR;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/cfgseq_chk.sv
module cfgseq_chk #(
   parameter int          ADDR_W    = 8,
   parameter logic [31:0] BASE_ADDR = 32'h0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              done,
   input logic              error,
   input logic              running,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_ready
);

   localparam logic [ADDR_W-1:0] A_UPD = ADDR_W'(BASE_ADDR + 32'h60);

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                  && $stable(bus_write) && $stable(bus_wdata));

   assert_done_error_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));

   assert_quiet_after_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !bus_valid && !running);

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bus_valid && !running);

   assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start && !running |=> running && !done && !error);

   assert_trigger_has_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_write && bus_addr == A_UPD && bus_wdata[8]
      |-> bus_wdata[4:0] != 5'd0);

endmodule

bind cfg_boot_seq cfgseq_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .done      (done),
   .error     (error),
   .running   (running),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_ready (bus_ready)
);

// File: tb/tb_cfg_boot_seq.sv
module tb_cfg_boot_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 8;
   localparam int LIMIT      = 60;   // 1 MHz x 60 us
   localparam int WATCHDOG   = 150000;

   localparam int        GBASE  [6] = '{6, 14, 3, 2, 2, 2};
   localparam int        GFIRST [6] = '{0, 3, 11, 12, 13, 14};
   localparam int        GCNT   [6] = '{3, 8, 1, 1, 1, 1};
   localparam logic [7:0]  WOFF [15] = '{8'h30, 8'h34, 8'h38, 8'h10, 8'h14, 8'h18, 8'h1C,
                                         8'h20, 8'h24, 8'h28, 8'h2C, 8'h40, 8'h50, 8'h50, 8'h50};
   localparam logic [31:0] WVAL [15] = '{32'h077706DB, 32'h05550249, 32'h00000111,
                                         32'hFEFEBFF7, 32'hFDFF7FEF, 32'hFBFFDEFB, 32'hB69B5555,
                                         32'h24929249, 32'h49241112, 32'h11112111, 32'h00008102,
                                         32'h000FC987, 32'h00000800, 32'h00000C00, 32'h00000400};

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic          done, error;
   logic [2:0]    err_group;
   logic [1:0]    err_poll;
   logic          bus_valid, bus_write;
   logic [AW-1:0] bus_addr;
   logic [31:0]   bus_wdata;
   logic          bus_ready;
   logic [31:0]   bus_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_boot_seq #(.ADDR_W(AW), .CLK_HZ(1_000_000), .TIMEOUT_US(LIMIT), .BASE_ADDR(32'h0)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
      .err_group(err_group), .err_poll(err_poll),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
   );

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   int wcount = 0;
   bit sb_on  = 0;

   typedef struct { logic [7:0] addr; logic [31:0] data; int req; } exp_t;
   exp_t sbq[$];

   // slave model knobs and state
   bit          slave_clr = 0;
   bit          busy_stuck = 0;
   bit          clr_stuck = 0;
   int          nack_entry = 31;
   logic [31:0] cmd_q;
   int          busy_cnt;
   logic [15:0] cfg_q;
   logic [15:0] ack_q;
   int          ack_tmr, clr_tmr;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n || slave_clr) begin
         bus_ready <= 1'b0;
         bus_rdata <= '0;
         cmd_q     <= '0;
         busy_cnt  <= 0;
         cfg_q     <= '0;
         ack_q     <= '0;
         ack_tmr   <= 0;
         clr_tmr   <= 0;
      end else begin
         if (ack_tmr == 1) ack_q[cfg_q[3:0]] <= 1'b1;
         if (ack_tmr > 0) ack_tmr <= ack_tmr - 1;
         if (clr_tmr == 1) ack_q <= '0;
         if (clr_tmr > 0) clr_tmr <= clr_tmr - 1;
         if (bus_valid && !bus_ready) begin
            bus_ready <= 1'b1;
            if (!bus_write) begin
               if (bus_addr == 8'h00) begin
                  bus_rdata <= cmd_q | {31'b0, busy_cnt != 0};
                  if (busy_cnt > 0 && !busy_stuck) busy_cnt <= busy_cnt - 1;
               end else if (bus_addr == 8'h60) begin
                  bus_rdata <= {ack_q, cfg_q};
               end else begin
                  bus_rdata <= '0;
               end
            end else begin
               if (bus_addr == 8'h00) begin
                  cmd_q <= bus_wdata;
                  if (bus_wdata[1]) busy_cnt <= 3;
               end else if (bus_addr == 8'h60) begin
                  cfg_q <= bus_wdata[15:0];
                  if (bus_wdata == 32'h0 && !clr_stuck) clr_tmr <= 8;
                  if (bus_wdata[8] && int'(bus_wdata[3:0]) != nack_entry) ack_tmr <= 10;
               end
            end
         end else begin
            bus_ready <= 1'b0;
         end
      end
   end

   // monitor: pops the scoreboard on every accepted write
   always @(negedge clk) begin
      if (rst_n && sb_on && bus_valid && bus_ready && bus_write) begin
         wcount++;
         if (bus_addr != 8'h00 && bus_addr != 8'h60)
            check(busy_cnt == 0, "R2", "word written while slave busy", busy_cnt, 0);
         if (sbq.size() == 0) begin
            check(1'b0, "R1", "unexpected write", {24'b0, bus_addr}, 32'hFFFFFFFF);
         end else begin
            exp_t e;
            e = sbq.pop_front();
            check(bus_addr == e.addr && bus_wdata == e.data, $sformatf("R%0d", e.req),
                  $sformatf("write addr %h", bus_addr), bus_wdata, e.data);
            if (bus_addr != e.addr)
               check(1'b0, $sformatf("R%0d", e.req), "write address",
                     {24'b0, bus_addr}, {24'b0, e.addr});
         end
      end
   end

   task automatic push(input logic [7:0] a, input logic [31:0] d, input int r);
      exp_t e;
      e.addr = a; e.data = d; e.req = r;
      sbq.push_back(e);
   endtask

   // driver: expected write stream from R1..R5
   task automatic push_run();
      for (int g = 0; g < 6; g++) begin
         push(8'h00, 32'h2, 2);                                  // R2 root set
         for (int w = 0; w < GCNT[g]; w++)
            push(WOFF[GFIRST[g] + w], WVAL[GFIRST[g] + w], 1);   // R1 words
         for (int k = 0; k < GCNT[g]; k++) begin
            logic [31:0] en;
            en = 32'(GBASE[g] - k);                               // R3 descending
            push(8'h60, en, 3);
            push(8'h60, en | 32'h100, 4);                         // R4 trigger
            push(8'h60, 32'h0, 5);                                // R5 clear
         end
      end
   endtask

   task automatic slave_reset();
      @(negedge clk) slave_clr = 1;
      @(negedge clk) slave_clr = 0;
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
   endtask

   task automatic wait_end(output int took);
      int t0;
      t0 = cyc;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (done || error) break;
      end
      took = cyc - t0;
   endtask

   task automatic run_clean(input bit extra_start);
      int took;
      slave_reset();
      sbq.delete();
      wcount = 0;
      push_run();
      sb_on = 1;
      pulse_start();
      if (extra_start) begin
         repeat (100) @(negedge clk);
         start = 1;                               // R8: ignored mid-run
         @(negedge clk) start = 0;
      end
      wait_end(took);
      check(done == 1'b1, "R7", "done after sequence", done, 1);
      check(error == 1'b0, "R7", "no error on clean run", error, 0);
      check(sbq.size() == 0, "R1", "expected writes left over", sbq.size(), 0);
      check(wcount == 66, "R8", "write count", wcount, 66);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (!done || bus_valid) begin
            check(1'b0, "R7", "done not held quietly", {done, bus_valid}, 2'b10);
            break;
         end
      end
      check(done == 1'b1, "R7", "done still held", done, 1);
      sb_on = 0;
   endtask

   task automatic run_fault(input int grp_exp, input int poll_exp);
      int  took;
      bit  quiet;
      slave_reset();
      sb_on = 0;
      pulse_start();
      check(done == 1'b0, "R7", "start clears done", done, 0);
      wait_end(took);
      check(error == 1'b1, "R6", "error on timeout", error, 1);
      check(done == 1'b0, "R6", "done low on timeout", done, 0);
      check(int'(err_group) == grp_exp, "R6", "err_group", err_group, grp_exp);
      check(int'(err_poll) == poll_exp, "R6", "err_poll", err_poll, poll_exp);
      check(took >= LIMIT, "R6", "timeout too early", took, LIMIT);
      quiet = 1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (bus_valid) quiet = 0;
      end
      check(quiet, "R6", "bus traffic after error", !quiet, 0);
   endtask

   initial begin
      rst_n = 0;
      start = 0;
      repeat (4) @(negedge clk);
      check(done == 1'b0, "R9", "reset done", done, 0);
      check(error == 1'b0, "R9", "reset error", error, 0);
      check(bus_valid == 1'b0, "R9", "reset bus_valid", bus_valid, 0);
      check(err_poll == 2'd3, "R9", "reset err_poll", err_poll, 3);
      rst_n = 1;
      repeat (3) @(negedge clk);

      run_clean(1'b1);

      nack_entry = 14;              // first commit of group 1 never acknowledged
      run_fault(1, 1);
      nack_entry = 31;

      busy_stuck = 1;               // ready bit never drops
      run_fault(0, 0);
      busy_stuck = 0;

      clr_stuck = 1;                // acknowledge never clears
      run_fault(0, 2);
      clr_stuck = 0;

      run_clean(1'b0);              // R7: restart after an error
      check(err_poll == 2'd3, "R7", "failure fields cleared", err_poll, 3);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wait (cyc >= WATCHDOG);
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule